// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block sits behind one fixed window of host physical address space and sends every memory access that lands in that window to one of up to sixteen downstream host-bridge ports. An upstream request carries an offset relative to the start of the window. The block adds the programmed window base to that offset to form the host physical address. It divides that address by the interleave granule and takes the result modulo the number of interleave targets to pick the port. It then forwards the request, carrying the full host address, and passes the port's response back upstream.

The configuration is static. It consists of the window base, the window size, the target count, a granule code and a mask of ports that are present. A request is unroutable when the configuration is illegal, when the offset falls outside the window, when the byte count is not 1 to 8, or when the selected port is absent. An unroutable request never reaches a port. The block completes it locally: a read returns zero data with an error, and a write is dropped and completes with no error. Only one request is in flight at a time. Both sides use valid/ready handshakes.

The control is a five-state machine:
- IDLE waits for a request and moves to ROUTE on acceptance.
- ROUTE registers the host address and the port. It then moves to ISSUE when the request is routable, or to REPLY when it is not.
- ISSUE moves to AWAIT once the port accepts the request.
- AWAIT moves to REPLY when the port response arrives.
- REPLY moves back to IDLE once the upstream side takes the response.

Top module: `ilv_window_router`

## Requirements
- R1: A routed request carries dn_req_addr = (cfg_base + up_req_addr) modulo 2^48. Its byte count, write flag and write data are passed through unchanged, with no alignment applied and the data bytes in little-endian order.
- R2: With granule code g (0 to 6, where 0 means 256 bytes), the granule is 256 << g bytes. The selected port is floor(host address / granule) mod cfg_ways and is driven on dn_req_port.
- R3: cfg_bad is 1 when any of three conditions holds: cfg_ways is not one of {1,2,3,4,6,8,12,16}, cfg_gran is above 6, or cfg_size[27:0] is not zero (the size is not a multiple of 256 MiB). While cfg_bad is 1, every access is unroutable.
- R4: An access is also unroutable when up_req_addr >= cfg_size, when up_req_size is outside 1 to 8, or when bit p of cfg_port_ok is 0 for the selected port p.
- R5: An unroutable read completes upstream with up_rsp_rdata = 0 and up_rsp_err = 1, and no downstream request is raised.
- R6: An unroutable write is dropped: no downstream request is raised, and it completes with up_rsp_err = 0.
- R7: For a routed access, the downstream response data and error flag are returned unchanged on up_rsp_rdata and up_rsp_err.
- R8: up_req_ready is 1 only in IDLE. No new request is accepted until the upstream response handshake of the current one has completed.
- R9: Once dn_req_valid is raised, it stays high with stable fields until dn_req_ready. Once up_rsp_valid is raised, it stays high with stable data until up_rsp_ready.
- R10: The routing decision takes one cycle. In the cycle after the second rising edge following acceptance, either dn_req_valid (routed) or up_rsp_valid (local) is high.
- R11: While reset is held, the block shows up_req_ready = 1, dn_req_valid = 0 and up_rsp_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 48 | Window base host address |
| cfg_size | input | 48 | Window size in bytes |
| cfg_ways | input | 5 | Number of interleave targets |
| cfg_gran | input | 3 | Granule code, granule = 256 << code |
| cfg_port_ok | input | 16 | One bit per port, 1 = port present |
| cfg_bad | output | 1 | Configuration is illegal |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request accepted |
| up_req_addr | input | 48 | Window-relative offset |
| up_req_size | input | 4 | Byte count |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_wdata | input | 64 | Write data |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response taken |
| up_rsp_rdata | output | 64 | Read data |
| up_rsp_err | output | 1 | Error response |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request accepted |
| dn_req_addr | output | 48 | Host physical address |
| dn_req_size | output | 4 | Byte count |
| dn_req_write | output | 1 | Write flag |
| dn_req_wdata | output | 64 | Write data |
| dn_req_port | output | 4 | Selected port index |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response taken |
| dn_rsp_rdata | input | 64 | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error flag |

## Verification
A wrong registered port or host address shows up on dn_req_port or dn_req_addr in the first cycle of ISSUE, two edges after acceptance. A wrong routable decision shows up in that same cycle, because the wrong one of dn_req_valid or up_rsp_valid goes high. A state machine that skips or repeats a state shows up within one cycle: the ready and valid pattern no longer matches the expected phase, for example up_req_ready high while a response is still pending. Stalls on both handshakes expose any register that changes while it is being held.

// File: rtl/ilvr_pkg.sv
package ilvr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROUTE,
        ST_ISSUE,
        ST_AWAIT,
        ST_REPLY
    } rtr_state_e;

    // Target count split into a power-of-two shift and an optional factor of three
    typedef struct packed {
        logic       ok;
        logic [2:0] shift;
        logic       three;
    } ways_dec_t;

    function automatic ways_dec_t decode_ways(input logic [4:0] ways);
        ways_dec_t d;
        d.ok    = 1'b1;
        d.shift = 3'd0;
        d.three = 1'b0;
        case (ways)
            5'd1:  d.shift = 3'd0;
            5'd2:  d.shift = 3'd1;
            5'd4:  d.shift = 3'd2;
            5'd8:  d.shift = 3'd3;
            5'd16: d.shift = 3'd4;
            5'd3:  d.three = 1'b1;
            5'd6:  begin d.shift = 3'd1; d.three = 1'b1; end
            5'd12: begin d.shift = 3'd2; d.three = 1'b1; end
            default: d.ok = 1'b0;
        endcase
        return d;
    endfunction

    // Residue accumulate: (a + b) mod 3, with a in 0..2 and b in 0..3
    function automatic logic [1:0] mod3_add(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'd3) s = s - 3'd3;
        return s[1:0];
    endfunction

endpackage

// File: rtl/ilvr_mod3.sv
module ilvr_mod3 import ilvr_pkg::*; #(
    parameter int W = 40
) (
    input  logic [W-1:0] value,
    output logic [1:0]   rem
);
    localparam int ND = (W + 1) / 2;
    localparam int PW = 2 * ND;

    logic [PW-1:0]       padded;
    logic [2*ND+1:0]     acc;

    assign padded    = PW'(value);
    assign acc[1:0]  = 2'd0;

    // 4 = 1 mod 3, so the residue is the sum of the base-4 digits mod 3
    for (genvar i = 0; i < ND; i++) begin : g_digit
        assign acc[2*i+3:2*i+2] = mod3_add(acc[2*i+1:2*i], padded[2*i+1:2*i]);
    end

    assign rem = acc[2*ND+1:2*ND];
endmodule

// File: rtl/ilvr_cfg_check.sv
module ilvr_cfg_check import ilvr_pkg::*; #(
    parameter int HPA_W      = 48,
    parameter int NPORT      = 16,
    parameter int GRAN_MAX   = 6,
    parameter int ALIGN_LOG2 = 28
) (
    input  logic [HPA_W-1:0]           cfg_size,
    input  logic [$clog2(NPORT):0]     cfg_ways,
    input  logic [2:0]                 cfg_gran,
    output logic                       cfg_ok,
    output logic [2:0]                 ways_shift,
    output logic                       ways_three
);
    localparam int WAYS_W = $clog2(NPORT) + 1;

    ways_dec_t dec;
    logic      size_ok;
    logic      gran_ok;
    logic      count_ok;

    always_comb begin
        dec      = decode_ways(5'(cfg_ways));
        size_ok  = (cfg_size[ALIGN_LOG2-1:0] == '0);
        gran_ok  = (cfg_gran <= 3'(GRAN_MAX));
        count_ok = dec.ok && (cfg_ways <= WAYS_W'(NPORT));
    end

    assign cfg_ok     = size_ok && gran_ok && count_ok;
    assign ways_shift = dec.shift;
    assign ways_three = dec.three;
endmodule

// File: rtl/ilvr_target_sel.sv
module ilvr_target_sel #(
    parameter int HPA_W  = 48,
    parameter int PORT_W = 4
) (
    input  logic [HPA_W-1:0]  hpa,
    input  logic [2:0]        gran,
    input  logic [2:0]        ways_shift,
    input  logic              ways_three,
    output logic [PORT_W-1:0] port
);
    localparam int GW = HPA_W - 8;

    logic [3:0]        shamt;
    logic [GW-1:0]     granule;
    logic [GW-1:0]     upper;
    logic [PORT_W:0]   mask;
    logic [PORT_W-1:0] low_part;
    logic [PORT_W-1:0] high_part;
    logic [1:0]        rem3;

    always_comb begin
        shamt    = 4'd8 + {1'b0, gran};
        granule  = GW'(hpa >> shamt);
        mask     = ((PORT_W+1)'(1) << ways_shift) - (PORT_W+1)'(1);
        low_part = granule[PORT_W-1:0] & mask[PORT_W-1:0];
        upper    = granule >> ways_shift;
    end

    ilvr_mod3 #(.W(GW)) u_mod3 (
        .value (upper),
        .rem   (rem3)
    );

    always_comb begin
        high_part = PORT_W'(rem3) << ways_shift;
        port      = ways_three ? (high_part | low_part) : low_part;
    end
endmodule

// File: rtl/ilv_window_router.sv
module ilv_window_router import ilvr_pkg::*; #(
    parameter int HPA_W  = 48,
    parameter int DATA_W = 64,
    parameter int NPORT  = 16,
    parameter int SIZE_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [HPA_W-1:0]          cfg_base,
    input  logic [HPA_W-1:0]          cfg_size,
    input  logic [$clog2(NPORT):0]    cfg_ways,
    input  logic [2:0]                cfg_gran,
    input  logic [NPORT-1:0]          cfg_port_ok,
    output logic                      cfg_bad,
    input  logic                      up_req_valid,
    output logic                      up_req_ready,
    input  logic [HPA_W-1:0]          up_req_addr,
    input  logic [SIZE_W-1:0]         up_req_size,
    input  logic                      up_req_write,
    input  logic [DATA_W-1:0]         up_req_wdata,
    output logic                      up_rsp_valid,
    input  logic                      up_rsp_ready,
    output logic [DATA_W-1:0]         up_rsp_rdata,
    output logic                      up_rsp_err,
    output logic                      dn_req_valid,
    input  logic                      dn_req_ready,
    output logic [HPA_W-1:0]          dn_req_addr,
    output logic [SIZE_W-1:0]         dn_req_size,
    output logic                      dn_req_write,
    output logic [DATA_W-1:0]         dn_req_wdata,
    output logic [$clog2(NPORT)-1:0]  dn_req_port,
    input  logic                      dn_rsp_valid,
    output logic                      dn_rsp_ready,
    input  logic [DATA_W-1:0]         dn_rsp_rdata,
    input  logic                      dn_rsp_err
);
    localparam int PORT_W    = $clog2(NPORT);
    localparam int MAX_BYTES = DATA_W / 8;

    rtr_state_e         state_q, state_d;

    logic [HPA_W-1:0]   ofs_q;
    logic [SIZE_W-1:0]  size_q;
    logic               wr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [HPA_W-1:0]   hpa_q;
    logic [PORT_W-1:0]  port_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               err_q;

    logic               cfg_ok;
    logic [2:0]         ways_shift;
    logic               ways_three;
    logic [HPA_W-1:0]   hpa_c;
    logic [PORT_W-1:0]  port_c;
    logic               routable_c;

    ilvr_cfg_check #(
        .HPA_W (HPA_W),
        .NPORT (NPORT)
    ) u_cfg (
        .cfg_size   (cfg_size),
        .cfg_ways   (cfg_ways),
        .cfg_gran   (cfg_gran),
        .cfg_ok     (cfg_ok),
        .ways_shift (ways_shift),
        .ways_three (ways_three)
    );

    assign hpa_c = cfg_base + ofs_q;

    ilvr_target_sel #(
        .HPA_W  (HPA_W),
        .PORT_W (PORT_W)
    ) u_sel (
        .hpa        (hpa_c),
        .gran       (cfg_gran),
        .ways_shift (ways_shift),
        .ways_three (ways_three),
        .port       (port_c)
    );

    always_comb begin
        routable_c = cfg_ok
                  && (ofs_q < cfg_size)
                  && (size_q != '0)
                  && (size_q <= SIZE_W'(MAX_BYTES))
                  && cfg_port_ok[port_c];
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (up_req_valid) state_d = ST_ROUTE;
            ST_ROUTE: state_d = routable_c ? ST_ISSUE : ST_REPLY;
            ST_ISSUE: if (dn_req_ready) state_d = ST_AWAIT;
            ST_AWAIT: if (dn_rsp_valid) state_d = ST_REPLY;
            ST_REPLY: if (up_rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q   <= '0;
            size_q  <= '0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            hpa_q   <= '0;
            port_q  <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (up_req_valid) begin
                    ofs_q   <= up_req_addr;
                    size_q  <= up_req_size;
                    wr_q    <= up_req_write;
                    wdata_q <= up_req_wdata;
                end
                ST_ROUTE: begin
                    hpa_q   <= hpa_c;
                    port_q  <= port_c;
                    rdata_q <= '0;
                    err_q   <= !wr_q;
                end
                ST_AWAIT: if (dn_rsp_valid) begin
                    rdata_q <= dn_rsp_rdata;
                    err_q   <= dn_rsp_err;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        up_req_ready = 1'b0;
        dn_req_valid = 1'b0;
        dn_rsp_ready = 1'b0;
        up_rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  up_req_ready = 1'b1;
            ST_ISSUE: dn_req_valid = 1'b1;
            ST_AWAIT: dn_rsp_ready = 1'b1;
            ST_REPLY: up_rsp_valid = 1'b1;
            default:  ;
        endcase
        dn_req_addr  = hpa_q;
        dn_req_size  = size_q;
        dn_req_write = wr_q;
        dn_req_wdata = wdata_q;
        dn_req_port  = port_q;
        up_rsp_rdata = rdata_q;
        up_rsp_err   = err_q;
        cfg_bad      = !cfg_ok;
    end
endmodule

// File: rtl/ilvr_chk.sv
module ilvr_chk #(
    parameter int HPA_W  = 48,
    parameter int DATA_W = 64,
    parameter int NPORT  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [HPA_W-1:0]         cfg_base,
    input logic [HPA_W-1:0]         cfg_size,
    input logic [$clog2(NPORT):0]   cfg_ways,
    input logic                     cfg_bad,
    input logic                     up_req_ready,
    input logic                     up_rsp_valid,
    input logic                     up_rsp_ready,
    input logic [DATA_W-1:0]        up_rsp_rdata,
    input logic                     up_rsp_err,
    input logic                     dn_req_valid,
    input logic                     dn_req_ready,
    input logic [HPA_W-1:0]         dn_req_addr,
    input logic [$clog2(NPORT)-1:0] dn_req_port
);
    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> ((dn_req_addr - cfg_base) < cfg_size));              // R1

    AST_PORT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> ({1'b0, dn_req_port} < cfg_ways));                   // R2

    AST_BAD_CFG_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |-> !dn_req_valid);                                           // R3

    AST_SINGLE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_ready |-> (!dn_req_valid && !up_rsp_valid));                   // R8

    AST_NO_DUAL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_req_valid && up_rsp_valid));                                     // R8

    AST_DN_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=>
            (dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_port)));  // R9

    AST_UP_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !up_rsp_ready) |=>
            (up_rsp_valid && $stable(up_rsp_rdata) && $stable(up_rsp_err)));  // R9
endmodule

bind ilv_window_router ilvr_chk #(
    .HPA_W  (HPA_W),
    .DATA_W (DATA_W),
    .NPORT  (NPORT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_base     (cfg_base),
    .cfg_size     (cfg_size),
    .cfg_ways     (cfg_ways),
    .cfg_bad      (cfg_bad),
    .up_req_ready (up_req_ready),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_ready (up_rsp_ready),
    .up_rsp_rdata (up_rsp_rdata),
    .up_rsp_err   (up_rsp_err),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_req_addr  (dn_req_addr),
    .dn_req_port  (dn_req_port)
);

// File: tb/ilv_window_router_tb_top.sv
module ilv_window_router_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  HPA_W  = 48;
    localparam int  DATA_W = 64;
    localparam int  NPORT  = 16;
    localparam longint unsigned HPA_MASK = (64'd1 << HPA_W) - 64'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [HPA_W-1:0]  cfg_base = '0;
    logic [HPA_W-1:0]  cfg_size = '0;
    logic [4:0]        cfg_ways = 5'd1;
    logic [2:0]        cfg_gran = 3'd0;
    logic [NPORT-1:0]  cfg_port_ok = '1;
    logic              cfg_bad;
    logic              up_req_valid = 1'b0;
    logic              up_req_ready;
    logic [HPA_W-1:0]  up_req_addr = '0;
    logic [3:0]        up_req_size = '0;
    logic              up_req_write = 1'b0;
    logic [DATA_W-1:0] up_req_wdata = '0;
    logic              up_rsp_valid;
    logic              up_rsp_ready = 1'b0;
    logic [DATA_W-1:0] up_rsp_rdata;
    logic              up_rsp_err;
    logic              dn_req_valid;
    logic              dn_req_ready = 1'b0;
    logic [HPA_W-1:0]  dn_req_addr;
    logic [3:0]        dn_req_size;
    logic              dn_req_write;
    logic [DATA_W-1:0] dn_req_wdata;
    logic [3:0]        dn_req_port;
    logic              dn_rsp_valid = 1'b0;
    logic              dn_rsp_ready;
    logic [DATA_W-1:0] dn_rsp_rdata = '0;
    logic              dn_rsp_err = 1'b0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_window_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_ways(cfg_ways),
        .cfg_gran(cfg_gran), .cfg_port_ok(cfg_port_ok), .cfg_bad(cfg_bad),
        .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
        .up_req_addr(up_req_addr), .up_req_size(up_req_size),
        .up_req_write(up_req_write), .up_req_wdata(up_req_wdata),
        .up_rsp_valid(up_rsp_valid), .up_rsp_ready(up_rsp_ready),
        .up_rsp_rdata(up_rsp_rdata), .up_rsp_err(up_rsp_err),
        .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready),
        .dn_req_addr(dn_req_addr), .dn_req_size(dn_req_size),
        .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata),
        .dn_req_port(dn_req_port),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
        .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
    );

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: legality, routability and port choice
    function automatic bit cfg_legal();
        int w;
        w = int'(cfg_ways);
        return (w == 1 || w == 2 || w == 3 || w == 4 || w == 6 || w == 8 ||
                w == 12 || w == 16) && (cfg_gran <= 3'd6) &&
               ((longint'(cfg_size) % (64'd1 << 28)) == 0);
    endfunction

    function automatic void model(input longint unsigned ofs, input int sz,
                                  output bit rt, output int port,
                                  output longint unsigned hpa);
        longint unsigned gsz;
        hpa  = (longint'(cfg_base) + ofs) & HPA_MASK;
        port = 0;
        rt   = cfg_legal();
        if (rt) begin
            gsz  = 64'd256 << cfg_gran;
            port = int'((hpa / gsz) % longint'(cfg_ways));
            rt   = (ofs < longint'(cfg_size)) && (sz >= 1) && (sz <= 8) &&
                   cfg_port_ok[port];
        end
    endfunction

    task automatic set_cfg(input longint unsigned base, input longint unsigned size,
                           input int ways, input int gran);
        @(negedge clk);
        cfg_base = HPA_W'(base);
        cfg_size = HPA_W'(size);
        cfg_ways = 5'(ways);
        cfg_gran = 3'(gran);
    endtask

    task automatic txn(input string rq, input longint unsigned ofs, input int sz,
                       input bit wr, input longint unsigned wd, input int stall,
                       input int hold, input bit derr);
        bit rt; int port; longint unsigned hpa; longint unsigned dret;
        model(ofs, sz, rt, port, hpa);
        @(negedge clk);
        chk("R8", "ready before accept", 64'(up_req_ready), 1);
        up_req_valid = 1'b1;
        up_req_addr  = HPA_W'(ofs);
        up_req_size  = 4'(sz);
        up_req_write = wr;
        up_req_wdata = wd;
        @(negedge clk);
        up_req_valid = 1'b0;
        chk("R8", "ready while routing", 64'(up_req_ready), 0);
        @(negedge clk);
        if (rt) begin
            chk("R10", "dn valid timing", 64'(dn_req_valid), 1);
            chk("R10", "no local rsp", 64'(up_rsp_valid), 0);
            chk("R1", "host address", 64'(dn_req_addr), hpa);
            chk({rq, " R2"}, "port", 64'(dn_req_port), longint'(port));
            chk("R1", "size", 64'(dn_req_size), longint'(sz));
            chk("R1", "write flag", 64'(dn_req_write), 64'(wr));
            chk("R1", "write data", dn_req_wdata, wd);
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk("R9", "dn valid held", 64'(dn_req_valid), 1);
                chk("R9", "dn addr held", 64'(dn_req_addr), hpa);
                chk("R8", "ready while busy", 64'(up_req_ready), 0);
            end
            dn_req_ready = 1'b1;
            @(negedge clk);
            dn_req_ready = 1'b0;
            chk("R9", "dn valid dropped", 64'(dn_req_valid), 0);
            chk("R8", "await rsp ready", 64'(dn_rsp_ready), 1);
            dret = {hpa[31:0], 28'hC0DE000, 4'(port)};
            dn_rsp_valid = 1'b1;
            dn_rsp_rdata = dret;
            dn_rsp_err   = derr;
            @(negedge clk);
            dn_rsp_valid = 1'b0;
            chk("R7", "rsp valid", 64'(up_rsp_valid), 1);
            chk("R7", "rsp data", up_rsp_rdata, dret);
            chk("R7", "rsp err", 64'(up_rsp_err), 64'(derr));
        end else begin
            dret = 0;
            chk({rq, " R10"}, "local rsp timing", 64'(up_rsp_valid), 1);
            chk({rq, " R4"}, "no dn request", 64'(dn_req_valid), 0);
            if (wr) begin
                chk({rq, " R6"}, "write err", 64'(up_rsp_err), 0);
            end else begin
                chk({rq, " R5"}, "read err", 64'(up_rsp_err), 1);
                chk({rq, " R5"}, "read data", up_rsp_rdata, 0);
            end
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk("R9", "rsp held", 64'(up_rsp_valid), 1);
            chk("R9", "rsp data held", up_rsp_rdata, dret);
            chk("R4", "no dn during reply", 64'(dn_req_valid), 0);
        end
        up_rsp_ready = 1'b1;
        @(negedge clk);
        up_rsp_ready = 1'b0;
        chk("R8", "rsp done", 64'(up_rsp_valid), 0);
        chk("R8", "back to idle", 64'(up_req_ready), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset ready", 64'(up_req_ready), 1);
        chk("R11", "reset dn valid", 64'(dn_req_valid), 0);
        chk("R11", "reset rsp valid", 64'(up_rsp_valid), 0);
        rst_n = 1'b1;

        // Four ways, 256-byte granule (code 0)
        set_cfg(64'h0012_3400_0000, 64'h4000_0000, 4, 0);
        chk("R3", "legal cfg", 64'(cfg_bad), 0);
        txn("R2", 64'h000, 8, 0, 0, 0, 0, 0);
        txn("R2", 64'h100, 8, 0, 0, 0, 0, 0);
        txn("R2", 64'h2ff, 1, 0, 0, 0, 0, 0);
        txn("R2", 64'h3f9, 8, 1, 64'h0807_0605_0403_0201, 2, 1, 0);

        // Three ways, 512-byte granule
        set_cfg(64'h0012_3400_0000, 64'h4000_0000, 3, 1);
        for (int i = 0; i < 5; i++) txn("R2", longint'(i) * 64'h200 + 64'h13, 4, 0, 0, 0, 0, 0);
        txn("R7", 64'h1234, 2, 0, 0, 1, 0, 1);

        // Twelve, six, sixteen, eight and one ways
        set_cfg(64'h0000_8000_0000, 64'h1000_0000, 12, 2);
        for (int i = 0; i < 13; i++) txn("R2", longint'(i) * 64'h400 + 64'h7, 8, 0, 0, 0, 0, 0);
        set_cfg(64'h0000_9000_0000, 64'h2000_0000, 6, 3);
        for (int i = 0; i < 7; i++) txn("R2", longint'(i) * 64'h7ff, 3, 1, 64'hAA, 0, 0, 0);
        set_cfg(64'h0001_0000_0000, 64'h4000_0000, 16, 6);
        txn("R2", 64'h0, 8, 0, 0, 0, 0, 0);
        txn("R2", 64'h5_4000, 8, 0, 0, 0, 2, 0);
        txn("R2", 64'h3fff_fff8, 8, 0, 0, 0, 0, 0);
        set_cfg(64'h0001_0000_0000, 64'h4000_0000, 8, 5);
        txn("R2", 64'h2_2000, 5, 0, 0, 0, 0, 0);
        set_cfg(64'h0001_0000_0000, 64'h1000_0000, 1, 0);
        txn("R2", 64'h0fff_ffff, 1, 1, 64'h55, 0, 0, 0);

        // Out of window, bad sizes, absent port
        set_cfg(64'h0012_3400_0000, 64'h4000_0000, 4, 0);
        txn("R4", 64'h4000_0000, 8, 0, 0, 0, 1, 0);
        txn("R6", 64'h4000_0000, 8, 1, 64'h1234, 0, 0, 0);
        txn("R4", 64'h100, 0, 0, 0, 0, 0, 0);
        txn("R4", 64'h100, 9, 1, 0, 0, 0, 0);
        cfg_port_ok[2] = 1'b0;
        txn("R4", 64'h200, 8, 0, 0, 0, 0, 0);
        txn("R6", 64'h200, 8, 1, 64'h77, 0, 0, 0);
        txn("R4", 64'h300, 8, 0, 0, 0, 0, 0);
        cfg_port_ok = '1;

        // Illegal configurations
        set_cfg(64'h0012_3400_0000, 64'h1000_0100, 4, 0);
        @(negedge clk);
        chk("R3", "size not 256MiB multiple", 64'(cfg_bad), 1);
        txn("R3", 64'h0, 8, 0, 0, 0, 0, 0);
        set_cfg(64'h0012_3400_0000, 64'h4000_0000, 5, 0);
        @(negedge clk);
        chk("R3", "five ways", 64'(cfg_bad), 1);
        txn("R3", 64'h0, 8, 1, 64'h9, 0, 0, 0);
        set_cfg(64'h0012_3400_0000, 64'h4000_0000, 4, 7);
        @(negedge clk);
        chk("R3", "granule code 7", 64'(cfg_bad), 1);
        txn("R3", 64'h0, 8, 0, 0, 0, 0, 0);
        set_cfg(64'h0012_3400_0000, 64'h4000_0000, 12, 6);
        @(negedge clk);
        chk("R3", "twelve ways legal", 64'(cfg_bad), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule